// File: doc/BRIEF.md
# Color-to-Gray Palette with ROM Autoload

This block turns a 4-bit IRGB pixel code into a 3-bit gray level for a monochrome panel. A table of 32 four-bit registers holds the mapping. The registers at indices 0 to 15 are the palette, one per color code, and the low three bits of each one select the gray level. The registers at indices 16 to 31 can be written, but the lookup never reads them. The pixel path reads the palette entry for the incoming code and registers the result on the dot clock.

The table can be filled in two ways, and a mode pin chooses between them. In host mode, a processor writes the registers through a simple strobe bus: chip select, write, a 5-bit index and 4-bit data. In ROM mode, the block loads itself once after reset. It steps a 5-bit ROM index from 0 to 31, holds each index for 16 dot clocks, takes the data on the last clock of each step and then raises a done flag. Reset, whether from power-up or from the reset pin, loads a default ramp into the palette.

Top module: `gray_palette`

## Requirements
- R1: While reset is low and after it is released, gray_o, load_done_o and rom_addr_o are 0. Reset loads palette entry c (c = 0..15) with the gray level c>>1 and clears registers 16..31 to 0. A later reset restores the same defaults.
- R2: gray_o equals the low three bits of palette entry pix_i, one clock edge after pix_i is presented. A new pix_i can be presented every cycle.
- R3: In host mode, a clock edge with cs_i=1 and wr_i=1 writes data_i into register addr_i. A lookup made after that edge returns the new value.
- R4: A host strobe with cs_i=0, or with wr_i=0, changes no register.
- R5: Bit 3 of each palette entry has no effect on gray_o. Only bits 2:0 are used.
- R6: Registers 16..31 can be written using the full 5-bit index. They never alias onto, or affect, the lookup of entries 0..15.
- R7: rom_mode_i is sampled only at the first clock edge after reset is released (1 = ROM autoload, 0 = host). Later changes to the pin have no effect until the next reset.
- R8: In ROM mode, rom_addr_o is 0 after the first edge that follows reset release. Each index k (0..31) is held for exactly 16 clocks, starting after edge 1+16k, and the index rises by one at each step.
- R9: In each ROM step, data_i is captured only in the step's last clock (at edge 17+16k). It is written into register k.
- R10: load_done_o rises after edge 513 following reset release and stays high. After that, rom_addr_o holds 31.
- R11: In ROM mode, host strobes are ignored, both during the load and after it completes.
- R12: In host mode, load_done_o stays 0 and rom_addr_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rom_mode_i | input | 1 | Load mode, sampled after reset: 1 = ROM autoload, 0 = host writes |
| cs_i | input | 1 | Host chip select |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | 5 | Host register index |
| data_i | input | 4 | Host write data, or ROM read data in ROM mode |
| rom_addr_o | output | 5 | ROM index driven during autoload |
| load_done_o | output | 1 | Autoload finished |
| pix_i | input | 4 | IRGB pixel code |
| gray_o | output | 3 | Registered gray level |

## Verification
The bench targets the edges of each ROM step. The ROM model drives corrupted data except in the final clock of a step, so a loader that captures early or late stores wrong gray levels. It also checks the index exactly at the 16/17 and 512/513 cycle boundaries, which exposes an off-by-one in the step counter or the done flag. A host write to index 16 is checked against entry 0, which catches an index truncated to four bits. A host strobe issued in the middle of the load, and one issued after it completes, must both leave the loaded values in place. Toggling the mode pin after reset in either mode must leave the running mode unchanged.

// File: rtl/gray_palette_pkg.sv
package gray_palette_pkg;
  typedef enum logic [1:0] {
    ST_START,
    ST_HOST,
    ST_LOAD,
    ST_DONE
  } pal_state_e;
endpackage

// File: rtl/pal_regfile.sv
module pal_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4,
  parameter int PIX_W  = 4,
  parameter int GRAY_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PIX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_word_o
);
  localparam int DEPTH      = 2 ** ADDR_W;
  localparam int NUM_COLORS = 2 ** PIX_W;

  logic [DATA_W-1:0] regs [DEPTH];

  function automatic logic [DATA_W-1:0] rst_val(int idx);
    if (idx < NUM_COLORS) return DATA_W'(idx >> (PIX_W - GRAY_W));
    return '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= rst_val(i);
    end else if (we_i) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  // palette occupies the lower half of the index space
  assign rd_word_o = regs[{{(ADDR_W-PIX_W){1'b0}}, rd_idx_i}];

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import gray_palette_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 4,
  parameter int STEP_CLKS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rom_mode_i,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              done_o
);
  localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(STEP_CLKS - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  pal_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] rom_addr_q;
  logic              load_fire, host_fire;

  assign load_fire = (state_q == ST_LOAD) && (cnt_q == CNT_LAST);
  assign host_fire = (state_q == ST_HOST) && cs_i && wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_START;
      cnt_q      <= '0;
      rom_addr_q <= '0;
    end else begin
      unique case (state_q)
        ST_START: state_q <= rom_mode_i ? ST_LOAD : ST_HOST;
        ST_LOAD: begin
          if (load_fire) begin
            cnt_q <= '0;
            if (rom_addr_q == ADDR_LAST) state_q <= ST_DONE;
            else rom_addr_q <= rom_addr_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign we_o       = load_fire | host_fire;
  assign waddr_o    = load_fire ? rom_addr_q : addr_i;
  assign wdata_o    = data_i;
  assign rom_addr_o = rom_addr_q;
  assign done_o     = (state_q == ST_DONE);

  a_r8_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_LOAD && !load_fire) || state_q == ST_DONE) |=> $stable(rom_addr_o));
  a_r8_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_fire && rom_addr_q != ADDR_LAST) |=> rom_addr_o == $past(rom_addr_o) + 1'b1);
  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  a_r12_host_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOST) |-> (!done_o && rom_addr_o == '0));
  a_r7_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOST) |=> (state_q == ST_HOST));
  a_r11_no_host_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_HOST && cs_i && wr_i && !load_fire) |-> !we_o);
endmodule

// File: rtl/gray_palette.sv
module gray_palette #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 4,
  parameter int PIX_W     = 4,
  parameter int GRAY_W    = 3,
  parameter int STEP_CLKS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rom_mode_i,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              load_done_o,
  input  logic [PIX_W-1:0]  pix_i,
  output logic [GRAY_W-1:0] gray_o
);
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rd_word;
  logic              unused_hi;

  pal_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_CLKS(STEP_CLKS)
  ) i_seq (
    .clk_i, .rst_ni, .rom_mode_i, .cs_i, .wr_i, .addr_i, .data_i,
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .rom_addr_o, .done_o(load_done_o)
  );

  pal_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIX_W(PIX_W), .GRAY_W(GRAY_W)
  ) i_regs (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .rd_idx_i(pix_i), .rd_word_o(rd_word)
  );

  // upper entry bits carry no gray information
  assign unused_hi = ^rd_word[DATA_W-1:GRAY_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gray_o <= '0;
    else         gray_o <= rd_word[GRAY_W-1:0];
  end

  a_r2_gray_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we) |=> gray_o == $past(rd_word[GRAY_W-1:0]));
endmodule

// File: tb/test_gray_palette.sv
module test_gray_palette;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rom_mode_i = 1'b0;
  logic       cs_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [3:0] data_i;
  logic [4:0] rom_addr_o;
  logic       load_done_o;
  logic [3:0] pix_i = '0;
  logic [2:0] gray_o;

  logic       rom_drive = 1'b0;
  logic       rom_good = 1'b0;
  logic [3:0] host_data = '0;
  int checks = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  function automatic logic [3:0] rom_fn(logic [4:0] a);
    return 4'((a * 7 + 3) & 15);
  endfunction

  // ROM model: valid only in the final clock of each step
  assign data_i = !rom_drive ? host_data
                : (rom_good ? rom_fn(rom_addr_o) : ~rom_fn(rom_addr_o));

  gray_palette i_gray_palette (
    .clk_i, .rst_ni, .rom_mode_i, .cs_i, .wr_i, .addr_i, .data_i,
    .rom_addr_o, .load_done_o, .pix_i, .gray_o
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk_i);
    rst_ni = 1'b0; rom_mode_i = mode; rom_drive = mode; rom_good = 1'b0;
    cs_i = 1'b0; wr_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 gray in reset", gray_o, 0);
    chk("R1 done in reset", load_done_o, 0);
    chk("R1 rom addr in reset", rom_addr_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic look(logic [3:0] pix, int exp, string tag);
    pix_i = pix;
    @(negedge clk_i);
    chk(tag, gray_o, exp);
  endtask

  task automatic host_wr(logic [4:0] a, logic [3:0] d, logic cs, logic wr);
    cs_i = cs; wr_i = wr; addr_i = a; host_data = d;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic t_defaults();
    do_reset(1'b0);
    for (int c = 0; c < 16; c++) look(4'(c), c >> 1, "R1 default / R2 lookup");
  endtask

  task automatic t_host_writes();
    host_wr(5'd5, 4'd6, 1'b1, 1'b1);
    look(4'd5, 6, "R3 host write");
    host_wr(5'd5, 4'd1, 1'b0, 1'b1);
    look(4'd5, 6, "R4 no cs");
    host_wr(5'd5, 4'd1, 1'b1, 1'b0);
    look(4'd5, 6, "R4 no wr");
    host_wr(5'd7, 4'hF, 1'b1, 1'b1);
    look(4'd7, 7, "R5 top bit set 15");
    host_wr(5'd3, 4'h9, 1'b1, 1'b1);
    look(4'd3, 1, "R5 top bit set 9");
    host_wr(5'd16, 4'd7, 1'b1, 1'b1);
    host_wr(5'd21, 4'd3, 1'b1, 1'b1);
    look(4'd0, 0, "R6 entry 0 untouched");
    look(4'd5, 6, "R6 entry 5 untouched");
    look(4'd7, 7, "R2 back to back");
    look(4'd3, 1, "R2 back to back");
  endtask

  task automatic t_host_mode_lock();
    int bad = 0;
    rom_mode_i = 1'b1;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk_i);
      if (rom_addr_o != 0 || load_done_o) bad++;
    end
    chk("R7/R12 host mode holds outputs", bad, 0);
    host_wr(5'd9, 4'd2, 1'b1, 1'b1);
    look(4'd9, 2, "R7 host writes still work");
    rom_mode_i = 1'b0;
  endtask

  task automatic t_rom_load();
    int addr_bad = 0;
    int done_bad = 0;
    do_reset(1'b1);
    for (int n = 1; n <= 520; n++) begin
      @(negedge clk_i);
      if (rom_addr_o != ((n <= 512) ? (n - 1) / 16 : 31)) addr_bad++;
      if (load_done_o != (n >= 513)) done_bad++;
      if (n == 16)  chk("R8 index 0 held 16 clocks", rom_addr_o, 0);
      if (n == 17)  chk("R8 index steps to 1", rom_addr_o, 1);
      if (n == 512) chk("R10 done not early", load_done_o, 0);
      if (n == 513) chk("R10 done after 513 edges", load_done_o, 1);
      if (n == 100) rom_mode_i = 1'b0;
      if (n == 200) begin cs_i = 1'b1; wr_i = 1'b1; addr_i = 5'd2; end
      if (n == 201) begin cs_i = 1'b0; wr_i = 1'b0; end
      rom_good = (n <= 512) && ((n - 1) % 16 == 15);
    end
    chk("R8 index sequence", addr_bad, 0);
    chk("R10 done timing", done_bad, 0);
    rom_drive = 1'b0;
    host_wr(5'd4, 4'd6, 1'b1, 1'b1);
    for (int c = 0; c < 16; c++) look(4'(c), int'(rom_fn(5'(c)) & 4'd7), "R9 loaded entry");
    look(4'd2, 1, "R11 strobe during load ignored");
    look(4'd4, 7, "R11 strobe after done ignored");
    chk("R10 index holds 31", rom_addr_o, 31);
  endtask

  task automatic t_reset_restore();
    do_reset(1'b0);
    look(4'd7, 3, "R1 defaults restored");
    look(4'd0, 0, "R1 defaults restored");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    t_defaults();
    t_host_writes();
    t_host_mode_lock();
    t_rom_load();
    t_reset_restore();
    finish_run();
  end
endmodule